// File: doc/BRIEF.md
# Hexagonal Neighbour-Coincidence Cluster Trigger

This block forms the first-level trigger decision for one cluster of a pixelated camera. Each clock it receives the discriminator bits of the 7 pixels of its own cluster and 5 bits from each of the 6 surrounding clusters. Together these cover a hexagonal region of 37 pixels. Every pixel bit first passes through its own programmable delay, which aligns the pixel timing. It is then stretched into a coincidence window of programmable length. The block raises a one-cycle trigger when the three pixels of any mutually adjacent triangle are active in the same cycle.

A dead time follows each trigger, during which no new trigger is issued. Each trigger pulse carries the cluster's 8-bit position identifier, so the same logic can be placed in every position of the camera. The local pixel bits are also forwarded to the neighbouring clusters, which lets the trigger regions overlap.

Delays, window length and dead time are loaded through a simple write port. The port takes an address and a data byte. All delays are whole clock ticks.

Top module: `hex_coinc_trigger`

## Requirements
- R1: The pixel vector is {nbrPix, localPix}, so index i<7 is localPix[i] and index 7+5s+j is nbrPix[5s+j]. Pixel positions use axial coordinates (q,r) with six directions D0..D5 = (1,0),(1,-1),(0,-1),(-1,0),(-1,1),(0,1). Index 0 sits at (0,0). Index i in 1..6 sits at D(i-1). For neighbour s and slot j, the positions are: j=0 at 2·Ds, j=1 at 2·Ds+D(s+2 mod 6), j=2 at 3·Ds, j=3 at 3·Ds+D(s+2), j=4 at 3·Ds+2·D(s+2).
- R2: A trigger is issued only when some triple of pairwise adjacent pixels (hex distance 1) is active together after delay and stretching. With zero delays, a one-cycle input pulse in cycle c gives trigOut high in cycle c+2 (two register stages).
- R3: A write to address a in 0..36 sets the delay of pixel a to cfgData[5:0] ticks (0..63), which shifts that pixel's contribution later by that many cycles.
- R4: A write to address 37 sets the window W = cfgData[3:0]+1 ticks. A delayed pixel edge counts as active for W cycles. For three pulses of one triangle, a trigger results exactly when the latest minus the earliest pulse cycle is below W.
- R5: trigOut is a one-cycle pulse. A write to address 38 sets the dead length L = cfgData[7:0]. After each pulse, trigOut stays low for at least L+1 cycles. A coincidence held high repeats the pulse every L+2 cycles.
- R6: trigTag equals the clusterId of the cycle before a pulse while trigOut is high, and is zero otherwise.
- R7: nbrOut equals localPix delayed by exactly one cycle, whatever the configuration or trigger state.
- R8: After reset: all delays are 0, W=1, L=0, trigOut and trigTag are 0, and no pixel activity from before reset can produce a trigger.
- R9: Writes to addresses 39..63 change none of the delay, window or dead-time settings.
- R10: Three active pixels in a straight line (for example indices 4, 0 and 1), or any two adjacent pixels alone, do not trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| localPix | input | 7 | Discriminator bits of the own cluster |
| nbrPix | input | 30 | Five bits from each of six surrounding clusters |
| clusterId | input | 8 | Position identifier of this cluster |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | Configuration address (pixel delay, window, dead time) |
| cfgData | input | 8 | Configuration write data |
| trigOut | output | 1 | One-cycle trigger pulse |
| trigTag | output | 8 | Cluster identifier attached to the pulse |
| nbrOut | output | 7 | Local pixel bits forwarded to the neighbours |

## Verification
Every cycle, the assertions check that a pulse never lasts two cycles and is always preceded by a triangle hit from the datapath. They also check that the tag is zero between pulses and matches the previous identifier during one, that a delayed pixel edge always shows up as stretched in the following cycle, and that the forwarded local bits lag by one cycle. Some behaviours only the bench's scenarios can show: the geometric correctness of the triangle set, the exact two-stage latency, delay alignment across pixels, the window boundary at spread W-1 versus W, the repetition period under dead time, and the ignored addresses. The bench does this by running a cycle-level reference model built from the requirements against directed and random pixel activity.

// File: rtl/hex_coinc_pkg.sv
package hex_coinc_pkg;

  localparam int NUM_LOCAL   = 7;
  localparam int NUM_NBR     = 6;
  localparam int PIX_PER_NBR = 5;
  localparam int NUM_PIX     = NUM_LOCAL + NUM_NBR * PIX_PER_NBR;
  localparam int DLY_W       = 6;
  localparam int WIN_W       = 4;
  localparam int DEAD_W      = 8;
  localparam int ID_W        = 8;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = $clog2(NUM_PIX + 2);
  localparam int WIN_ADDR    = NUM_PIX;
  localparam int DEAD_ADDR   = NUM_PIX + 1;

  typedef struct packed {
    logic              dlyWe;
    logic [ADDR_W-1:0] dlyIdx;
    logic [DLY_W-1:0]  dlyVal;
    logic              winWe;
    logic [WIN_W-1:0]  winVal;
  } cfgStrobe_t;

  function automatic int dirQ(input int d);
    case (d % 6)
      0: return 1;
      1: return 1;
      2: return 0;
      3: return -1;
      4: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int dirR(input int d);
    case (d % 6)
      0: return 0;
      1: return -1;
      2: return -1;
      3: return 0;
      4: return 1;
      default: return 1;
    endcase
  endfunction

  // Axial coordinate of a pixel index: centre, first ring, then one sextant
  // of rings two and three per neighbour cluster.
  function automatic int pixQ(input int idx);
    int s, j, ring, step;
    if (idx == 0) return 0;
    if (idx < NUM_LOCAL) return dirQ(idx - 1);
    s    = (idx - NUM_LOCAL) / PIX_PER_NBR;
    j    = (idx - NUM_LOCAL) % PIX_PER_NBR;
    ring = (j < 2) ? 2 : 3;
    step = (j < 2) ? j : j - 2;
    return ring * dirQ(s) + step * dirQ(s + 2);
  endfunction

  function automatic int pixR(input int idx);
    int s, j, ring, step;
    if (idx == 0) return 0;
    if (idx < NUM_LOCAL) return dirR(idx - 1);
    s    = (idx - NUM_LOCAL) / PIX_PER_NBR;
    j    = (idx - NUM_LOCAL) % PIX_PER_NBR;
    ring = (j < 2) ? 2 : 3;
    step = (j < 2) ? j : j - 2;
    return ring * dirR(s) + step * dirR(s + 2);
  endfunction

  function automatic int idxAt(input int q, input int r);
    for (int i = 0; i < NUM_PIX; i++) begin
      if (pixQ(i) == q && pixR(i) == r) return i;
    end
    return -1;
  endfunction

endpackage

// File: rtl/hex_coinc_datapath.sv
module hex_coinc_datapath
  import hex_coinc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PIX-1:0]   pixVec,
  input  cfgStrobe_t           cfgStb,
  output logic                 hit,
  output logic [NUM_LOCAL-1:0] nbrOut
);

  localparam int MAX_DLY = (1 << DLY_W) - 1;
  localparam int NUM_TRI = 2 * NUM_PIX;

  logic [WIN_W-1:0]   winQ;
  logic [NUM_PIX-1:0] dlyVec;
  logic [NUM_PIX-1:0] stretchVec;
  logic [NUM_TRI-1:0] triHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      winQ <= '0;
    end else if (cfgStb.winWe) begin
      winQ <= cfgStb.winVal;
    end
  end

  // Forward the raw local bits to the surrounding clusters.
  always_ff @(posedge clk) begin
    nbrOut <= pixVec[NUM_LOCAL-1:0];
  end

  // Per-pixel delay line and window stretcher.
  for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
    logic [MAX_DLY-1:0] shiftQ;
    logic [DLY_W-1:0]   dlyQ;
    logic [WIN_W:0]     cntQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        shiftQ <= '0;
        dlyQ   <= '0;
        cntQ   <= '0;
      end else begin
        shiftQ <= {shiftQ[MAX_DLY-2:0], pixVec[p]};
        if (cfgStb.dlyWe && cfgStb.dlyIdx == ADDR_W'(p)) begin
          dlyQ <= cfgStb.dlyVal;
        end
        if (dlyVec[p]) begin
          cntQ <= (WIN_W+1)'(winQ) + 1'b1;
        end else if (cntQ != '0) begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end

    assign dlyVec[p]     = (dlyQ == '0) ? pixVec[p] : shiftQ[dlyQ - 1'b1];
    assign stretchVec[p] = (cntQ != '0);
  end

  // Two triangle orientations anchored at every pixel; kept only where
  // both partners lie inside the region.
  for (genvar a = 0; a < NUM_PIX; a++) begin : g_tri
    localparam int QA  = pixQ(a);
    localparam int RA  = pixR(a);
    localparam int PB  = idxAt(QA + 1, RA);
    localparam int PCA = idxAt(QA, RA + 1);
    localparam int PCB = idxAt(QA + 1, RA - 1);
    if (PB >= 0 && PCA >= 0) begin : g_up
      assign triHit[2*a] = stretchVec[a] & stretchVec[PB] & stretchVec[PCA];
    end else begin : g_up_none
      assign triHit[2*a] = 1'b0;
    end
    if (PB >= 0 && PCB >= 0) begin : g_dn
      assign triHit[2*a+1] = stretchVec[a] & stretchVec[PB] & stretchVec[PCB];
    end else begin : g_dn_none
      assign triHit[2*a+1] = 1'b0;
    end
  end

  assign hit = |triHit;

  AST_STRETCH_COVER: assert property (@(posedge clk) disable iff (rst)
    (dlyVec != '0) |=> ((stretchVec & $past(dlyVec)) == $past(dlyVec))); // R4

  AST_LOCAL_FORWARD: assert property (@(posedge clk) disable iff (rst)
    nbrOut == $past(pixVec[NUM_LOCAL-1:0])); // R7

endmodule

// File: rtl/hex_coinc_ctrl.sv
module hex_coinc_ctrl
  import hex_coinc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              hit,
  input  logic [ID_W-1:0]   clusterId,
  output cfgStrobe_t        cfgStb,
  output logic              trigOut,
  output logic [ID_W-1:0]   trigTag
);

  logic [DEAD_W-1:0] deadLenQ;
  logic [DEAD_W:0]   deadCntQ;
  logic              fire;

  always_comb begin
    cfgStb.dlyWe  = cfgWe && (cfgAddr < ADDR_W'(NUM_PIX));
    cfgStb.dlyIdx = cfgAddr;
    cfgStb.dlyVal = cfgData[DLY_W-1:0];
    cfgStb.winWe  = cfgWe && (cfgAddr == ADDR_W'(WIN_ADDR));
    cfgStb.winVal = cfgData[WIN_W-1:0];
  end

  assign fire = hit && (deadCntQ == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      deadLenQ <= '0;
      deadCntQ <= '0;
      trigOut  <= 1'b0;
      trigTag  <= '0;
    end else begin
      if (cfgWe && cfgAddr == ADDR_W'(DEAD_ADDR)) begin
        deadLenQ <= cfgData[DEAD_W-1:0];
      end
      if (fire) begin
        deadCntQ <= (DEAD_W+1)'(deadLenQ) + 1'b1;
      end else if (deadCntQ != '0) begin
        deadCntQ <= deadCntQ - 1'b1;
      end
      trigOut <= fire;
      trigTag <= fire ? clusterId : '0;
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    trigOut |=> !trigOut); // R5

  AST_FIRE_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    trigOut |-> $past(hit)); // R2

  AST_TAG_IDLE: assert property (@(posedge clk) disable iff (rst)
    !trigOut |-> (trigTag == '0)); // R6

  AST_TAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    trigOut |-> (trigTag == $past(clusterId))); // R6

endmodule

// File: rtl/hex_coinc_trigger.sv
module hex_coinc_trigger
  import hex_coinc_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NUM_LOCAL-1:0]                 localPix,
  input  logic [NUM_NBR*PIX_PER_NBR-1:0]       nbrPix,
  input  logic [ID_W-1:0]                      clusterId,
  input  logic                                 cfgWe,
  input  logic [ADDR_W-1:0]                    cfgAddr,
  input  logic [DATA_W-1:0]                    cfgData,
  output logic                                 trigOut,
  output logic [ID_W-1:0]                      trigTag,
  output logic [NUM_LOCAL-1:0]                 nbrOut
);

  cfgStrobe_t         cfgStb;
  logic               hit;
  logic [NUM_PIX-1:0] pixVec;

  assign pixVec = {nbrPix, localPix};

  hex_coinc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .hit       (hit),
    .clusterId (clusterId),
    .cfgStb    (cfgStb),
    .trigOut   (trigOut),
    .trigTag   (trigTag)
  );

  hex_coinc_datapath u_dp (
    .clk    (clk),
    .rst    (rst),
    .pixVec (pixVec),
    .cfgStb (cfgStb),
    .hit    (hit),
    .nbrOut (nbrOut)
  );

endmodule

// File: tb/hex_coinc_trigger_tb.sv
module hex_coinc_trigger_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [36:0] pixDrive = '0;
  logic [7:0]  clusterId = 8'h00;
  logic        cfgWe = 1'b0;
  logic [5:0]  cfgAddr = '0;
  logic [7:0]  cfgData = '0;
  logic        trigOut;
  logic [7:0]  trigTag;
  logic [6:0]  nbrOut;

  always #5 clk = ~clk;

  hex_coinc_trigger u_dut (
    .clk       (clk),
    .rst       (rst),
    .localPix  (pixDrive[6:0]),
    .nbrPix    (pixDrive[36:7]),
    .clusterId (clusterId),
    .cfgWe     (cfgWe),
    .cfgAddr   (cfgAddr),
    .cfgData   (cfgData),
    .trigOut   (trigOut),
    .trigTag   (trigTag),
    .nbrOut    (nbrOut)
  );

  int    checks = 0;
  int    fails = 0;
  int    pulseCnt = 0;
  string curReq = "R8";

  // ---------------- geometry from R1 ----------------
  function automatic int dq(int d);
    int t[6] = '{1, 1, 0, -1, -1, 0};
    return t[d % 6];
  endfunction
  function automatic int dr(int d);
    int t[6] = '{0, -1, -1, 0, 1, 1};
    return t[d % 6];
  endfunction
  function automatic void hexPos(int i, output int q, output int r);
    int s, j, k, m;
    if (i == 0) begin q = 0; r = 0; end
    else if (i < 7) begin q = dq(i - 1); r = dr(i - 1); end
    else begin
      s = (i - 7) / 5; j = (i - 7) % 5;
      k = (j < 2) ? 2 : 3; m = (j < 2) ? j : j - 2;
      q = k * dq(s) + m * dq(s + 2);
      r = k * dr(s) + m * dr(s + 2);
    end
  endfunction
  function automatic bit adj(int a, int b);
    int qa, ra, qb, rb, x, y, z;
    hexPos(a, qa, ra); hexPos(b, qb, rb);
    x = qa - qb; y = ra - rb; z = x + y;
    if (x < 0) x = -x;
    if (y < 0) y = -y;
    if (z < 0) z = -z;
    return (x + y + z) == 2;
  endfunction

  int triA[64], triB[64], triC[64];
  int nTri = 0;

  function automatic bit refHit(logic [36:0] v);
    for (int t = 0; t < nTri; t++)
      if (v[triA[t]] && v[triB[t]] && v[triC[t]]) return 1'b1;
    return 1'b0;
  endfunction

  // ---------------- reference model ----------------
  logic [36:0] hist[128];
  int          mDly[37];
  int          mW = 1;
  int          mDead = 0;
  longint      cyc = 0;
  longint      lastFire = -1000;
  logic        expTrig = 0;
  logic [7:0]  expTag = 0;
  logic [6:0]  expNbr = 0;
  bit          started = 0;

  always @(posedge clk) begin
    logic [36:0] stv;
    longint      x;
    bit          f;
    if (rst) begin
      cyc = 0; lastFire = -1000; expTrig = 0; expTag = 0;
      mW = 1; mDead = 0;
      for (int p = 0; p < 37; p++) mDly[p] = 0;
    end else begin
      hist[cyc % 128] = pixDrive;
      stv = '0;
      for (int p = 0; p < 37; p++)
        for (int k = 1; k <= mW; k++) begin
          x = cyc - k - mDly[p];
          if (x >= 0 && hist[x % 128][p]) stv[p] = 1'b1;
        end
      f = refHit(stv) && (cyc + 1 - lastFire >= mDead + 2);
      expTrig = f;
      expTag  = f ? clusterId : 8'h00;
      if (f) lastFire = cyc + 1;
      if (cfgWe) begin
        if (cfgAddr < 37) mDly[cfgAddr] = int'(cfgData[5:0]);
        else if (cfgAddr == 37) mW = int'(cfgData[3:0]) + 1;
        else if (cfgAddr == 38) mDead = int'(cfgData);
      end
      cyc++;
    end
    expNbr  = pixDrive[6:0];
    started = 1;
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (trigOut !== expTrig || trigTag !== expTag) begin
        fails++;
        $display("FAIL %s trig/tag act=%0b/%0h exp=%0b/%0h at cycle %0d",
                 curReq, trigOut, trigTag, expTrig, expTag, cyc);
      end
      checks++;
      if (nbrOut !== expNbr) begin
        fails++;
        $display("FAIL R7 nbrOut act=%0h exp=%0h", nbrOut, expNbr);
      end
      if (trigOut === 1'b1) pulseCnt++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(int a, int d);
    @(negedge clk); cfgWe = 1'b1; cfgAddr = 6'(a); cfgData = 8'(d);
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic idle(int n);
    pixDrive = '0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [36:0] bits3(int a, int b, int c);
    logic [36:0] v = '0;
    v[a] = 1; v[b] = 1; v[c] = 1;
    return v;
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired act=running exp=done");
    finishRun();
  end

  initial begin
    int seed;
    int pc;
    seed = $urandom(32'd20231);
    for (int i = 0; i < 37; i++)
      for (int j = i + 1; j < 37; j++)
        for (int k = j + 1; k < 37; k++)
          if (adj(i, j) && adj(j, k) && adj(i, k) && nTri < 64) begin
            triA[nTri] = i; triB[nTri] = j; triC[nTri] = k; nTri++;
          end

    // R8: reset state, stale activity during reset must not trigger
    pixDrive = bits3(0, 1, 2);
    repeat (4) @(negedge clk);
    pixDrive = '0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(trigOut == 1'b0, "R8 no trigger after reset", int'(trigOut), 0);
    check(trigTag == 8'h00, "R8 tag clear after reset", int'(trigTag), 0);
    check(nTri == 54, "R1 triangle count of region", nTri, 54);

    // R2: two-stage latency on triangle 0,1,2
    curReq = "R2";
    clusterId = 8'h5A;
    pixDrive = bits3(0, 1, 2);
    @(negedge clk); pixDrive = '0;
    check(trigOut == 1'b0, "R2 latency stage one", int'(trigOut), 0);
    @(negedge clk);
    check(trigOut == 1'b1, "R2 latency stage two", int'(trigOut), 1);
    check(trigTag == 8'h5A, "R6 tag during pulse", int'(trigTag), 8'h5A);
    @(negedge clk);
    check(trigOut == 1'b0, "R5 pulse single cycle", int'(trigOut), 0);
    idle(5);

    // R10: straight line and adjacent pair do not trigger
    curReq = "R10";
    #1 pulseCnt = 0;
    pixDrive = bits3(4, 0, 1);
    @(negedge clk); idle(6);
    pixDrive = bits3(0, 1, 1);
    @(negedge clk); idle(6);
    #1 check(pulseCnt == 0, "R10 line and pair silent", pulseCnt, 0);

    // R3: delays align staggered pulses
    curReq = "R3";
    cfgWrite(0, 5); cfgWrite(2, 3);
    idle(2);
    #1 pulseCnt = 0;
    pixDrive = bits3(0, 0, 0); @(negedge clk);
    pixDrive = '0;             @(negedge clk);
    pixDrive = bits3(2, 2, 2); @(negedge clk);
    pixDrive = '0; repeat (2) @(negedge clk);
    pixDrive = bits3(1, 1, 1); @(negedge clk);
    idle(10);
    #1 check(pulseCnt == 1, "R3 aligned by delays", pulseCnt, 1);
    cfgWrite(0, 0); cfgWrite(2, 0);
    idle(2);
    #1 pulseCnt = 0;
    pixDrive = bits3(0, 0, 0); @(negedge clk);
    pixDrive = '0;             @(negedge clk);
    pixDrive = bits3(2, 2, 2); @(negedge clk);
    pixDrive = '0; repeat (2) @(negedge clk);
    pixDrive = bits3(1, 1, 1); @(negedge clk);
    idle(10);
    #1 check(pulseCnt == 0, "R3 misaligned without delays", pulseCnt, 0);

    // R4: window boundary, W=4
    curReq = "R4";
    cfgWrite(37, 3);
    idle(3);
    #1 pulseCnt = 0;
    pixDrive = bits3(0, 0, 0); @(negedge clk);
    pixDrive = bits3(1, 1, 1); @(negedge clk);
    pixDrive = '0;             @(negedge clk);
    pixDrive = bits3(2, 2, 2); @(negedge clk);
    idle(10);
    #1 check(pulseCnt == 1, "R4 spread W-1 fires", pulseCnt, 1);
    #1 pulseCnt = 0;
    pixDrive = bits3(0, 0, 0); @(negedge clk);
    pixDrive = '0; repeat (3) @(negedge clk);
    pixDrive = bits3(1, 2, 2); @(negedge clk);
    idle(10);
    #1 check(pulseCnt == 0, "R4 spread W silent", pulseCnt, 0);

    // R5: dead time L=5, held coincidence for 30 cycles
    curReq = "R5";
    cfgWrite(37, 0); cfgWrite(38, 5);
    idle(3);
    #1 pulseCnt = 0;
    pixDrive = bits3(0, 1, 2);
    repeat (30) @(negedge clk);
    idle(12);
    #1 check(pulseCnt == 5, "R5 repeat period L+2", pulseCnt, 5);

    // R9: writes above 38 ignored
    curReq = "R9";
    cfgWrite(38, 0);
    cfgWrite(45, 8'hFF); cfgWrite(63, 8'hFF); cfgWrite(39, 8'h0F);
    idle(3);
    #1 pulseCnt = 0;
    pixDrive = bits3(0, 1, 2); @(negedge clk);
    idle(20);
    #1 check(pulseCnt == 1, "R9 window and dead unchanged", pulseCnt, 1);

    // Random activity against the model (R2 R3 R4 R5 R6 R7 R9)
    curReq = "R2-random";
    for (int seg = 0; seg < 16; seg++) begin
      idle(100);
      for (int w = 0; w < 6; w++) cfgWrite($urandom % 64, $urandom % 64);
      cfgWrite(37, $urandom % 16);
      cfgWrite(38, $urandom % 41);
      clusterId = 8'($urandom);
      pc = 5 + ($urandom % 12);
      for (int c = 0; c < 150; c++) begin
        logic [36:0] v;
        for (int p = 0; p < 37; p++) v[p] = (($urandom % pc) == 0);
        pixDrive = v;
        @(negedge clk);
      end
    end
    idle(100);
    finishRun();
  end

endmodule